// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This block keeps the byte-wide status word of a serial port that runs either as an asynchronous receiver/transmitter or as a synchronous shift port. The block does not move any data itself. The transmit buffer, the transmit shifter and the receive deframer report their events to it as single-cycle strobes. From those strobes it keeps the transmit-side flags, a small queue of per-character error bits for the receive buffer, an overrun flag and a wake flag for stop mode. The CPU reads the whole word at all times on `status`, and it writes the word through a write strobe.

Four interrupt requests come out of the block. Each one is its flag gated by an enable input. A write with the soft-reset bit set clears the port's state. It also sends a one-cycle reset pulse to the transmit and receive datapaths.

Top module: `sport_status`

## Requirements
- R1: After reset, `status` reads 0x80. Bit layout: [7] tx buffer empty, [6] tx complete, [5] rx data ready, [4] wake, [3] soft reset (always reads 0), [2] overrun, [1] frame error, [0] parity error.
- R2: Bit 7 drops in the cycle after a `tx_buf_wr` and rises in the cycle after a `tx_buf_load` with no write in the same cycle. When both strobes come together, the write wins.
- R3: Bit 6 is set after `tx_shift_done` when bit 7 is 1 and no `tx_buf_wr` comes in the same cycle. `txc_ack`, or a register write with bit 6 = 0, clears it. A set in the same cycle wins over the clear.
- R4: The receive buffer holds up to RX_DEPTH characters. Bit 5 is 1 while at least one character is unread. A `rx_buf_rd` removes the oldest character, and an arriving frame is accepted in the same cycle when space exists or when a read frees a slot.
- R5: The receive pin is seen after a SYNC_STAGES-flop synchronizer that resets to 1. Bit 4 is set when the synchronized pin is 0 while both `uart_mode` and `stop_mode` are 1. Only a register write with bit 4 = 0 clears it, and a set wins over that clear.
- R6: A register write with bit 3 = 1 leaves `status` at 0x80 in the next cycle, empties the receive buffer, resets the synchronizer and raises `unit_rst` for exactly that one cycle. The other bits of that write are ignored.
- R7: Bit 2 is set when a frame arrives while the buffer is full and no read happens in that cycle. That frame is discarded. Any `rx_buf_rd` clears bit 2.
- R8: Bits 1 and 0 show the frame-error and parity-error bits of the oldest unread character. A character's frame error is stored only when `uart_mode` is 1. Its parity error is stored only when both `uart_mode` and `parity_en` are 1.
- R9: Register writes have no effect on bits 7, 5, 2, 1 and 0. Writing 1 to bit 6 or bit 4 has no effect.
- R10: Each interrupt output equals its status bit ANDed with its enable: `irq_dre` uses bit 7, `irq_txc` bit 6, `irq_rxc` bit 5 and `irq_wake` bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| status | output | 8 | Current status word |
| tx_buf_wr | input | 1 | CPU wrote the transmit buffer |
| tx_buf_load | input | 1 | Buffer byte moved into the shifter |
| tx_shift_done | input | 1 | Shifter finished its last frame |
| txc_ack | input | 1 | Transmit-complete interrupt serviced |
| rx_buf_rd | input | 1 | CPU read the receive data register |
| rx_frame_done | input | 1 | A received frame completed |
| rx_frame_err | input | 1 | Stop bit of that frame sampled as 0 |
| rx_parity_err | input | 1 | Parity check of that frame failed |
| uart_mode | input | 1 | 1 = asynchronous mode, 0 = synchronous shift mode |
| parity_en | input | 1 | Parity checking enabled |
| stop_mode | input | 1 | CPU is in stop mode |
| rx_pin | input | 1 | Raw receive line |
| en_dre | input | 1 | Enable for buffer-empty interrupt |
| en_txc | input | 1 | Enable for transmit-complete interrupt |
| en_rxc | input | 1 | Enable for receive-ready interrupt |
| en_wake | input | 1 | Enable for wake interrupt |
| irq_dre | output | 1 | Buffer-empty interrupt request |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_rxc | output | 1 | Receive-ready interrupt request |
| irq_wake | output | 1 | Wake interrupt request |
| unit_rst | output | 1 | One-cycle reset pulse to the datapaths |

## Verification
The bench drives long pseudo-random runs of every strobe against an arithmetic model of the queue. The runs cover these cases:
- A read and a frame arrival in the same cycle while the buffer is full. A design that declares overrun here would drop a character it had room for.
- Error bits that must follow the head character as the queue drains. A design that keeps one sticky error bit would report an error against a clean character.
- Set-versus-clear collisions on transmit-complete and wake. A design with the wrong priority loses an interrupt.
- A soft reset issued in the middle of traffic. A design that clears only the register, or that stretches `unit_rst`, leaves stale characters behind or holds the datapaths in reset too long.

// File: rtl/sps_pkg.sv
// Shared definitions for the serial port status unit.
// Holds the bit positions of the status word and the per-character error record.
package sps_pkg;
    localparam int BIT_DRE  = 7;
    localparam int BIT_TXC  = 6;
    localparam int BIT_RXC  = 5;
    localparam int BIT_WAKE = 4;
    localparam int BIT_SRST = 3;
    localparam int BIT_OVR  = 2;
    localparam int BIT_FE   = 1;
    localparam int BIT_PE   = 0;
    localparam logic [7:0] STATUS_RST = 8'h80;

    typedef struct packed {
        logic fe;
        logic pe;
    } rx_err_t;
endpackage

// File: rtl/sps_tx_flags.sv
// Transmit-side flags: buffer empty and transmit complete.
// Assumes every input is a single-cycle strobe. clr is the soft reset from the top.
module sps_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tx_wr,
    input  logic tx_load,
    input  logic tx_done,
    input  logic txc_ack,
    input  logic txc_wclr,
    output logic dre,
    output logic txc
);
    logic dre_q, txc_q, txc_set;

    // Complete only when the shifter is done and nothing waits in the buffer.
    assign txc_set = tx_done && dre_q && !tx_wr;

    // Buffer occupancy: a write beats a load in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  dre_q <= 1'b1;
        else if (tx_wr)     dre_q <= 1'b0;
        else if (tx_load)   dre_q <= 1'b1;
    end

    // Transmit-complete: a set wins over an acknowledge or a write-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              txc_q <= 1'b0;
        else if (txc_set)               txc_q <= 1'b1;
        else if (txc_ack || txc_wclr)   txc_q <= 1'b0;
    end

    assign dre = dre_q;
    assign txc = txc_q;

    p_dre_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !clr) |=> !dre_q);
    p_txc_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (txc_ack && !txc_set && !clr) |=> !txc_q);
endmodule

// File: rtl/sps_rx_queue.sv
// Receive-side occupancy and error tracking.
// Keeps one error record for each unread character, oldest first.
// Assumes rd means the CPU read the receive data register this cycle.
module sps_rx_queue
    import sps_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arrive,
    input  logic arr_fe,
    input  logic arr_pe,
    input  logic rd,
    output logic rxc,
    output logic ovr,
    output logic fe,
    output logic pe
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q, cnt_d, wr_idx;
    rx_err_t ent_q [DEPTH];
    rx_err_t ent_d [DEPTH];
    logic ovr_q, ovr_d, pop, push, full;

    assign full   = (cnt_q == CNT_FULL);
    assign pop    = rd && (cnt_q != '0);
    assign push   = arrive && (!full || pop);
    assign wr_idx = cnt_q - (pop ? CNT_W'(1) : CNT_W'(0));

    // Next queue contents: shift on pop, then place the new record at the tail.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i + 1];
            ent_d[DEPTH-1] = '0;
        end
        for (int i = 0; i < DEPTH; i++)
            if (push && wr_idx == CNT_W'(i)) ent_d[i] = '{fe: arr_fe, pe: arr_pe};
    end

    // Next occupancy and overrun state.
    always_comb begin
        cnt_d = cnt_q + (push ? CNT_W'(1) : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
        if (arrive && full && !pop) ovr_d = 1'b1;
        else if (rd)                ovr_d = 1'b0;
        else                        ovr_d = ovr_q;
    end

    // State registers: cleared by reset or by the soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            ovr_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            ovr_q <= ovr_d;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign rxc = (cnt_q != '0);
    assign ovr = ovr_q;
    assign fe  = rxc && ent_q[0].fe;
    assign pe  = rxc && ent_q[0].pe;

    p_ovr_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> ($past(cnt_q) == CNT_FULL && $past(arrive)));
    p_last_read_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !arrive && cnt_q == CNT_W'(1)) |=> !rxc);
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);
endmodule

// File: rtl/sps_wake.sv
// Stop-mode wake detector.
// Synchronizes the raw receive pin and sets a sticky flag on a low level
// in asynchronous stop mode. Assumes the idle line level is high.
module sps_wake #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pin,
    input  logic uart_mode,
    input  logic stop_mode,
    input  logic wclr,
    output logic wake
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic wake_q, wake_set;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single-stage capture of the pin.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) sync_q <= '1;
                else               sync_q <= pin;
            end
        end else begin : g_chain
            // Multi-stage synchronizer chain, newest sample in bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) sync_q <= '1;
                else               sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign wake_set = uart_mode && stop_mode && !sync_q[SYNC_STAGES-1];

    // Sticky wake flag: only a software write-clear drops it, and a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) wake_q <= 1'b0;
        else if (wake_set) wake_q <= 1'b1;
        else if (wclr)     wake_q <= 1'b0;
    end

    assign wake = wake_q;

    p_wake_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> $past(uart_mode && stop_mode));
endmodule

// File: rtl/sport_status.sv
// Serial port status flag unit, top level.
// Decodes writes to the status word, issues the soft reset, assembles the
// status word and gates the interrupt requests. All event inputs are
// single-cycle strobes from the serial datapaths.
module sport_status
    import sps_pkg::*;
#(
    parameter int RX_DEPTH    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] status,
    input  logic       tx_buf_wr,
    input  logic       tx_buf_load,
    input  logic       tx_shift_done,
    input  logic       txc_ack,
    input  logic       rx_buf_rd,
    input  logic       rx_frame_done,
    input  logic       rx_frame_err,
    input  logic       rx_parity_err,
    input  logic       uart_mode,
    input  logic       parity_en,
    input  logic       stop_mode,
    input  logic       rx_pin,
    input  logic       en_dre,
    input  logic       en_txc,
    input  logic       en_rxc,
    input  logic       en_wake,
    output logic       irq_dre,
    output logic       irq_txc,
    output logic       irq_rxc,
    output logic       irq_wake,
    output logic       unit_rst
);
    logic srst_req, srst_q, plain_wr;
    logic dre, txc, rxc, wake, ovr, fe, pe;

    assign srst_req = reg_wr && reg_wdata[BIT_SRST];
    assign plain_wr = reg_wr && !reg_wdata[BIT_SRST];

    // One-cycle reset pulse that follows a soft-reset write.
    always_ff @(posedge clk) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= srst_req;
    end

    sps_tx_flags u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (srst_req),
        .tx_wr    (tx_buf_wr),
        .tx_load  (tx_buf_load),
        .tx_done  (tx_shift_done),
        .txc_ack  (txc_ack),
        .txc_wclr (plain_wr && !reg_wdata[BIT_TXC]),
        .dre      (dre),
        .txc      (txc)
    );

    sps_rx_queue #(.DEPTH(RX_DEPTH)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (srst_req),
        .arrive (rx_frame_done),
        .arr_fe (rx_frame_err && uart_mode),
        .arr_pe (rx_parity_err && uart_mode && parity_en),
        .rd     (rx_buf_rd),
        .rxc    (rxc),
        .ovr    (ovr),
        .fe     (fe),
        .pe     (pe)
    );

    sps_wake #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst_req),
        .pin       (rx_pin),
        .uart_mode (uart_mode),
        .stop_mode (stop_mode),
        .wclr      (plain_wr && !reg_wdata[BIT_WAKE]),
        .wake      (wake)
    );

    // Status word assembly; the soft-reset bit always reads 0.
    always_comb begin
        status           = '0;
        status[BIT_DRE]  = dre;
        status[BIT_TXC]  = txc;
        status[BIT_RXC]  = rxc;
        status[BIT_WAKE] = wake;
        status[BIT_OVR]  = ovr;
        status[BIT_FE]   = fe;
        status[BIT_PE]   = pe;
    end

    assign irq_dre  = dre  && en_dre;
    assign irq_txc  = txc  && en_txc;
    assign irq_rxc  = rxc  && en_rxc;
    assign irq_wake = wake && en_wake;
    assign unit_rst = srst_q;

    p_srst_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unit_rst |-> (status == STATUS_RST));
    p_srst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_rst && !srst_req) |=> !unit_rst);
endmodule

// File: tb/tb_sport_status.sv
// Self-checking bench: directed checks, then a long pseudo-random sweep
// compared against an arithmetic model of the status word.
module tb_sport_status;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;
    localparam int SYNC       = 2;
    localparam int SWEEP      = 6000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, tx_buf_wr = 0, tx_buf_load = 0, tx_shift_done = 0, txc_ack = 0;
    logic rx_buf_rd = 0, rx_frame_done = 0, rx_frame_err = 0, rx_parity_err = 0;
    logic uart_mode = 1, parity_en = 1, stop_mode = 0, rx_pin = 1;
    logic en_dre = 1, en_txc = 1, en_rxc = 1, en_wake = 1;
    logic [7:0] reg_wdata = 0, status;
    logic irq_dre, irq_txc, irq_rxc, irq_wake, unit_rst;

    int vectors = 0, fails = 0;
    bit done = 0;

    // model state
    logic m_dre, m_txc, m_wake, m_ovr, m_urst;
    logic [SYNC-1:0] m_sync;
    int   m_cnt;
    logic m_fe [DEPTH];
    logic m_pe [DEPTH];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    sport_status #(.RX_DEPTH(DEPTH), .SYNC_STAGES(SYNC)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {m_dre, m_txc, m_cnt != 0, m_wake, 1'b0, m_ovr,
                (m_cnt != 0) && m_fe[0], (m_cnt != 0) && m_pe[0]};
    endfunction

    task automatic m_reset();
        m_dre = 1; m_txc = 0; m_wake = 0; m_ovr = 0; m_cnt = 0; m_sync = '1;
        for (int i = 0; i < DEPTH; i++) begin m_fe[i] = 0; m_pe[i] = 0; end
    endtask

    // Model update for one clock edge, from the inputs driven for that edge.
    task automatic m_step();
        logic srst, full, pop, push, wset, tset;
        srst = reg_wr && reg_wdata[3];
        m_urst = srst;
        if (srst) begin m_reset(); return; end
        tset = tx_shift_done && m_dre && !tx_buf_wr;
        if (tset) m_txc = 1;
        else if (txc_ack || (reg_wr && !reg_wdata[6])) m_txc = 0;
        if (tx_buf_wr) m_dre = 0; else if (tx_buf_load) m_dre = 1;
        wset = uart_mode && stop_mode && !m_sync[SYNC-1];
        if (wset) m_wake = 1; else if (reg_wr && !reg_wdata[4]) m_wake = 0;
        m_sync = {m_sync[SYNC-2:0], rx_pin};
        full = (m_cnt == DEPTH);
        pop  = rx_buf_rd && m_cnt != 0;
        push = rx_frame_done && (!full || pop);
        if (rx_frame_done && full && !pop) m_ovr = 1; else if (rx_buf_rd) m_ovr = 0;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin m_fe[i] = m_fe[i+1]; m_pe[i] = m_pe[i+1]; end
            m_fe[DEPTH-1] = 0; m_pe[DEPTH-1] = 0;
            m_cnt--;
        end
        if (push) begin
            m_fe[m_cnt] = rx_frame_err && uart_mode;
            m_pe[m_cnt] = rx_parity_err && uart_mode && parity_en;
            m_cnt++;
        end
    endtask

    task automatic idle();
        reg_wr = 0; tx_buf_wr = 0; tx_buf_load = 0; tx_shift_done = 0; txc_ack = 0;
        rx_buf_rd = 0; rx_frame_done = 0; rx_frame_err = 0; rx_parity_err = 0;
    endtask

    // One cycle: apply driven inputs at the edge, update model, compare after the edge.
    task automatic cycle();
        @(posedge clk);
        m_step();
        #1;
        chk("R2 dre", {7'd0, status[7]}, {7'd0, m_status()[7]});
        chk("R3 txc", {7'd0, status[6]}, {7'd0, m_status()[6]});
        chk("R4 rxc", {7'd0, status[5]}, {7'd0, m_status()[5]});
        chk("R5 wake", {7'd0, status[4]}, {7'd0, m_status()[4]});
        chk("R7 ovr", {7'd0, status[2]}, {7'd0, m_status()[2]});
        chk("R8 fe/pe", {6'd0, status[1:0]}, {6'd0, m_status()[1:0]});
        chk("R6 unit_rst/bit3", {6'd0, unit_rst, status[3]}, {6'd0, m_urst, 1'b0});
        chk("R10 irq", {4'd0, irq_dre, irq_txc, irq_rxc, irq_wake},
            {4'd0, m_status()[7] & en_dre, m_status()[6] & en_txc,
             m_status()[5] & en_rxc, m_status()[4] & en_wake});
        @(negedge clk);
        idle();
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        logic [31:0] x;
        x = v ^ (v << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        m_reset(); m_urst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk("R1 reset value", status, 8'h80);
        chk("R10 irq after reset", {4'd0, irq_dre, irq_txc, irq_rxc, irq_wake}, 8'h08);

        // R9: writes try to set read-only bits and bits 6/4 via 1; nothing changes.
        reg_wr = 1; reg_wdata = 8'hF7; cycle();
        chk("R9 write ignored", status, 8'h80);
        // Fill the buffer with errored characters, then check head binding (R8).
        rx_frame_done = 1; rx_frame_err = 1; cycle();
        rx_frame_done = 1; rx_parity_err = 1; cycle();
        chk("R8 head fe", status, 8'hA2);
        rx_frame_done = 1; cycle();
        chk("R7 overrun", status, 8'hA6);
        reg_wr = 1; reg_wdata = 8'h00; cycle();
        chk("R9 ovr/fe survive write", status, 8'hA6);
        rx_buf_rd = 1; cycle();
        chk("R8 next head pe", status, 8'hA1);
        // Read and arrival together while one unread character remains.
        rx_buf_rd = 1; rx_frame_done = 1; cycle();
        chk("R4 read+arrive", status, 8'hA0);
        // Transmit sequence (R2, R3).
        tx_buf_wr = 1; cycle();
        chk("R2 dre low", status, 8'h20);
        tx_buf_load = 1; cycle();
        tx_shift_done = 1; cycle();
        chk("R3 txc set", status, 8'hE0);
        txc_ack = 1; cycle();
        chk("R3 txc ack", status, 8'hA0);
        // Soft reset mid-traffic (R6).
        reg_wr = 1; reg_wdata = 8'h08; cycle();
        chk("R6 soft reset", status, 8'h80);
        cycle();
        chk("R6 pulse one cycle", {7'd0, unit_rst}, 8'h00);

        // Pseudo-random sweep over all strobes and modes.
        for (int n = 0; n < SWEEP; n++) begin
            lfsr = nxt(lfsr);
            tx_buf_wr     = lfsr[2:0] == 0;
            tx_buf_load   = lfsr[4:3] == 0;
            tx_shift_done = lfsr[6:5] == 0;
            txc_ack       = lfsr[9:7] == 0;
            rx_buf_rd     = lfsr[11:10] == 0;
            rx_frame_done = lfsr[13:12] != 0 && lfsr[14];
            rx_frame_err  = lfsr[15];
            rx_parity_err = lfsr[16];
            stop_mode     = lfsr[17];
            rx_pin        = lfsr[18] | lfsr[19];
            en_dre = lfsr[20]; en_txc = lfsr[21]; en_rxc = lfsr[22]; en_wake = lfsr[23];
            reg_wr        = lfsr[27:24] == 0;
            reg_wdata     = {lfsr[31:28], lfsr[30] & lfsr[31] & lfsr[29], lfsr[2:0]};
            if (n % 500 == 0) begin uart_mode = lfsr[5]; parity_en = lfsr[6]; end
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule